// File: doc/BRIEF.md
# Dual-Subcarrier Uplink Response Encoder

This block turns a stream of response bytes into the on/off control for a tag's load-modulation switch. It runs from the 13.56 MHz carrier clock and pulls bytes from a transmit queue through a valid/ready pair. Each frame is a start pattern, the bytes least significant bit first, and an end pattern that is the start pattern played backwards. The encoder then returns to idle. Two configuration inputs are captured when a frame begins. One picks one subcarrier or two. The other picks the high or the low data rate.

With one subcarrier, every half-bit is either silence or a burst at fc/32. With two subcarriers, every half-bit is a burst, at fc/32 (the lower subcarrier) or at fc/28 (the higher subcarrier). A bit is therefore binary FM with a Manchester shape. Every burst segment starts with the switch closed and holds a whole number of subcarrier periods, so the phase carries on cleanly across boundaries. The low rate stretches every segment by four.

Top module: `uplink_resp_encoder`

## Requirements
- R1: While reset is asserted, and afterwards with no queued byte, load_mod, busy and tx_ready are all low.
- R2: A frame starts on the clock edge at which the encoder is idle and tx_valid is high. busy is high from the next cycle until the frame ends. cfg_dual and cfg_low_rate are sampled on that edge, and changes to them during the frame have no effect on the output.
- R3: A lower-subcarrier burst toggles load_mod every 16 carrier cycles. A higher-subcarrier burst toggles it every 14 cycles. Every burst segment begins high, and every high run lasts exactly 14 or 16 cycles.
- R4: At the high rate, a silent or lower-subcarrier half-bit lasts 16 subcarrier half-periods (256 cycles), and a higher-subcarrier half-bit lasts 18 half-periods (252 cycles). At the low rate, both counts are multiplied by 4.
- R5: With one subcarrier (cfg_dual=0), a 0 bit is a lower-subcarrier burst followed by silence, and a 1 bit is silence followed by a burst.
- R6: With two subcarriers (cfg_dual=1), a 0 bit is the lower subcarrier followed by the higher one, and a 1 bit is the higher subcarrier followed by the lower one.
- R7: The start pattern is three half-bit units of the 1-leading symbol (silence, or the higher subcarrier), then three units of the lower subcarrier, then a 1 bit.
- R8: The end pattern is a 0 bit, then three units of the lower subcarrier, then three units of silence or the higher subcarrier. In the cycle after it, busy is low and load_mod is low.
- R9: Bytes are sent in queue order, bit 0 first. tx_ready is high for exactly one cycle, the last cycle of the start pattern or the last cycle of a byte's final half-bit, and only when a byte is taken.
- R10: A byte taken with tx_last=1 is the final byte. If tx_valid is low at the end of the start pattern or at the end of a byte, the end pattern follows at once and nothing is popped.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Carrier clock (13.56 MHz) |
| rst_n | input | 1 | Asynchronous active-low reset |
| cfg_dual | input | 1 | 1 selects two subcarriers, 0 selects one |
| cfg_low_rate | input | 1 | 1 selects the low data rate |
| tx_valid | input | 1 | Head of the transmit queue holds a byte |
| tx_data | input | 8 | Byte at the head of the queue |
| tx_last | input | 1 | The head byte is the last of the frame |
| tx_ready | output | 1 | Pop strobe; the head byte is taken on this edge |
| load_mod | output | 1 | Load-switch control |
| busy | output | 1 | A frame is being sent |

## Verification
The byte handover and the end of a segment fall in the same cycle. The pop strobe, the restart of the subcarrier divider and the choice between the next byte and the end pattern are all decided on one edge. The bench provokes this by queuing several bytes, by leaving the queue empty at a byte boundary, and by withdrawing tx_valid before the start pattern ends. It also flips both configuration inputs in the middle of a frame. Each frame is judged cycle by cycle against a segment list computed in the bench, covering load_mod, the exact tx_ready cycles and busy.

// File: rtl/uplink_enc_pkg.sv
package uplink_enc_pkg;

  typedef enum logic [1:0] {
    FR_IDLE = 2'd0,
    FR_SOF  = 2'd1,
    FR_DATA = 2'd2,
    FR_EOF  = 2'd3
  } frame_state_e;

  typedef enum logic [1:0] {
    SK_GAP  = 2'd0,
    SK_LOW  = 2'd1,
    SK_HIGH = 2'd2
  } seg_kind_e;

endpackage

// File: rtl/uplink_subcarrier_div.sv
// Half-period divider: raises tick in the last cycle of each subcarrier
// half-period and flips phase after it. A restart aligns a new segment.
module uplink_subcarrier_div #(
  parameter int DIV_LO = 16,
  parameter int DIV_HI = 14
) (
  input  logic clk,
  input  logic rst_n,
  input  logic run,
  input  logic restart,
  input  logic use_high,
  output logic tick,
  output logic phase
);

  localparam int DIV_MAX = (DIV_LO > DIV_HI) ? DIV_LO : DIV_HI;
  localparam int CNT_W   = (DIV_MAX > 2) ? $clog2(DIV_MAX) : 1;

  logic [CNT_W-1:0] cnt_q, cnt_d;
  logic             phase_q, phase_d;
  logic [CNT_W-1:0] limit;

  assign limit = use_high ? CNT_W'(DIV_HI - 1) : CNT_W'(DIV_LO - 1);
  assign tick  = run && (cnt_q == limit);
  assign phase = phase_q;

  always_comb begin
    cnt_d   = cnt_q;
    phase_d = phase_q;
    if (restart) begin
      cnt_d   = '0;
      phase_d = 1'b1;
    end else if (run) begin
      if (tick) begin
        cnt_d   = '0;
        phase_d = ~phase_q;
      end else begin
        cnt_d = cnt_q + 1'b1;
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cnt_q   <= '0;
      phase_q <= 1'b0;
    end else begin
      cnt_q   <= cnt_d;
      phase_q <= phase_d;
    end
  end

endmodule

// File: rtl/uplink_seg_timer.sv
// Counts half-period ticks; done marks the final cycle of a segment.
module uplink_seg_timer #(
  parameter int TICK_W = 8
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              restart,
  input  logic              tick,
  input  logic [TICK_W-1:0] target,
  output logic              done
);

  logic [TICK_W-1:0] tcnt_q, tcnt_d;

  assign done = tick && (tcnt_q == (target - 1'b1));

  always_comb begin
    tcnt_d = tcnt_q;
    if (restart) begin
      tcnt_d = '0;
    end else if (tick) begin
      tcnt_d = tcnt_q + 1'b1;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      tcnt_q <= '0;
    end else begin
      tcnt_q <= tcnt_d;
    end
  end

endmodule

// File: rtl/uplink_frame_seq.sv
// Frame sequencer: walks start pattern, data half-bits and end pattern,
// picks the current segment kind and length, and pops queue bytes.
module uplink_frame_seq
  import uplink_enc_pkg::*;
#(
  parameter int BYTE_W        = 8,
  parameter int HALF_LO_TICKS = 16,
  parameter int HALF_HI_TICKS = 18,
  parameter int SOF_LONG      = 3,
  parameter int RATE_SCALE    = 4,
  parameter int TICK_W        = 8
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              cfg_dual,
  input  logic              cfg_low_rate,
  input  logic              tx_valid,
  input  logic [BYTE_W-1:0] tx_data,
  input  logic              tx_last,
  input  logic              seg_done,
  output logic              tx_ready,
  output logic              active,
  output logic              restart,
  output logic              use_high,
  output logic              burst,
  output logic [TICK_W-1:0] seg_target
);

  localparam int BIT_W = (BYTE_W > 2) ? $clog2(BYTE_W) : 1;

  frame_state_e      state_q, state_d;
  logic [1:0]        step_q, step_d;
  logic [BIT_W-1:0]  bit_q, bit_d;
  logic [BYTE_W-1:0] shreg_q, shreg_d;
  logic              last_q, last_d;
  logic              dual_q, dual_d;
  logic              low_q, low_d;

  logic      sym_b;
  logic      long_seg;
  seg_kind_e kind;
  logic      start;
  logic      sof_end;
  logic      byte_end;
  logic      take;
  int        ticks;

  // Segment description: symbol B leads a 1 bit, symbol A leads a 0 bit.
  always_comb begin
    sym_b    = 1'b0;
    long_seg = 1'b0;
    unique case (state_q)
      FR_SOF: begin
        sym_b    = ~step_q[0];
        long_seg = ~step_q[1];
      end
      FR_EOF: begin
        sym_b    = step_q[0];
        long_seg = step_q[1];
      end
      FR_DATA: begin
        sym_b    = shreg_q[0] ^ step_q[0];
        long_seg = 1'b0;
      end
      default: begin
        sym_b    = 1'b0;
        long_seg = 1'b0;
      end
    endcase
  end

  always_comb begin
    if (!sym_b) begin
      kind = SK_LOW;
    end else if (dual_q) begin
      kind = SK_HIGH;
    end else begin
      kind = SK_GAP;
    end
  end

  assign use_high = (kind == SK_HIGH);
  assign burst    = (kind != SK_GAP);

  always_comb begin
    ticks = use_high ? HALF_HI_TICKS : HALF_LO_TICKS;
    if (long_seg) begin
      ticks = ticks * SOF_LONG;
    end
    if (low_q) begin
      ticks = ticks * RATE_SCALE;
    end
    seg_target = TICK_W'(ticks);
  end

  assign active   = (state_q != FR_IDLE);
  assign start    = (state_q == FR_IDLE) && tx_valid;
  assign sof_end  = (state_q == FR_SOF) && seg_done && (step_q == 2'd3);
  assign byte_end = (state_q == FR_DATA) && seg_done && step_q[0] &&
                    (bit_q == BIT_W'(BYTE_W - 1));
  assign take     = tx_valid && (sof_end || (byte_end && !last_q));
  assign tx_ready = take;
  assign restart  = start || (active && seg_done);

  always_comb begin
    state_d = state_q;
    step_d  = step_q;
    bit_d   = bit_q;
    shreg_d = shreg_q;
    last_d  = last_q;
    dual_d  = dual_q;
    low_d   = low_q;
    unique case (state_q)
      FR_IDLE: begin
        if (tx_valid) begin
          state_d = FR_SOF;
          step_d  = 2'd0;
          dual_d  = cfg_dual;
          low_d   = cfg_low_rate;
        end
      end
      FR_SOF: begin
        if (seg_done) begin
          if (step_q == 2'd3) begin
            step_d  = 2'd0;
            state_d = take ? FR_DATA : FR_EOF;
          end else begin
            step_d = step_q + 2'd1;
          end
        end
      end
      FR_DATA: begin
        if (seg_done) begin
          if (!step_q[0]) begin
            step_d = 2'd1;
          end else begin
            step_d = 2'd0;
            if (bit_q == BIT_W'(BYTE_W - 1)) begin
              state_d = take ? FR_DATA : FR_EOF;
            end else begin
              bit_d   = bit_q + 1'b1;
              shreg_d = shreg_q >> 1;
            end
          end
        end
      end
      FR_EOF: begin
        if (seg_done) begin
          if (step_q == 2'd3) begin
            state_d = FR_IDLE;
            step_d  = 2'd0;
          end else begin
            step_d = step_q + 2'd1;
          end
        end
      end
      default: state_d = FR_IDLE;
    endcase
    if (take) begin
      shreg_d = tx_data;
      last_d  = tx_last;
      bit_d   = '0;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state_q <= FR_IDLE;
      step_q  <= 2'd0;
      bit_q   <= '0;
      shreg_q <= '0;
      last_q  <= 1'b0;
      dual_q  <= 1'b0;
      low_q   <= 1'b0;
    end else begin
      state_q <= state_d;
      step_q  <= step_d;
      bit_q   <= bit_d;
      shreg_q <= shreg_d;
      last_q  <= last_d;
      dual_q  <= dual_d;
      low_q   <= low_d;
    end
  end

endmodule

// File: rtl/uplink_resp_encoder.sv
module uplink_resp_encoder #(
  parameter int BYTE_W        = 8,
  parameter int DIV_LO        = 16,
  parameter int DIV_HI        = 14,
  parameter int HALF_LO_TICKS = 16,
  parameter int HALF_HI_TICKS = 18,
  parameter int SOF_LONG      = 3,
  parameter int RATE_SCALE    = 4
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              cfg_dual,
  input  logic              cfg_low_rate,
  input  logic              tx_valid,
  input  logic [BYTE_W-1:0] tx_data,
  input  logic              tx_last,
  output logic              tx_ready,
  output logic              load_mod,
  output logic              busy
);

  localparam int MAX_HALF  = (HALF_HI_TICKS > HALF_LO_TICKS) ? HALF_HI_TICKS : HALF_LO_TICKS;
  localparam int MAX_TICKS = MAX_HALF * SOF_LONG * RATE_SCALE;
  localparam int TICK_W    = $clog2(MAX_TICKS + 1);

  // Reset: asserted asynchronously, released on a clock edge.
  logic [1:0] rst_pipe_q;
  logic       rst_core_n;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rst_pipe_q <= 2'b00;
    end else begin
      rst_pipe_q <= {rst_pipe_q[0], 1'b1};
    end
  end
  assign rst_core_n = rst_pipe_q[1];

  logic              active;
  logic              restart;
  logic              use_high;
  logic              burst;
  logic              tick;
  logic              phase;
  logic              seg_done;
  logic [TICK_W-1:0] seg_target;

  uplink_frame_seq #(
    .BYTE_W        (BYTE_W),
    .HALF_LO_TICKS (HALF_LO_TICKS),
    .HALF_HI_TICKS (HALF_HI_TICKS),
    .SOF_LONG      (SOF_LONG),
    .RATE_SCALE    (RATE_SCALE),
    .TICK_W        (TICK_W)
  ) u_seq (
    .clk          (clk),
    .rst_n        (rst_core_n),
    .cfg_dual     (cfg_dual),
    .cfg_low_rate (cfg_low_rate),
    .tx_valid     (tx_valid),
    .tx_data      (tx_data),
    .tx_last      (tx_last),
    .seg_done     (seg_done),
    .tx_ready     (tx_ready),
    .active       (active),
    .restart      (restart),
    .use_high     (use_high),
    .burst        (burst),
    .seg_target   (seg_target)
  );

  uplink_subcarrier_div #(
    .DIV_LO (DIV_LO),
    .DIV_HI (DIV_HI)
  ) u_div (
    .clk      (clk),
    .rst_n    (rst_core_n),
    .run      (active),
    .restart  (restart),
    .use_high (use_high),
    .tick     (tick),
    .phase    (phase)
  );

  uplink_seg_timer #(
    .TICK_W (TICK_W)
  ) u_timer (
    .clk     (clk),
    .rst_n   (rst_core_n),
    .restart (restart),
    .tick    (tick),
    .target  (seg_target),
    .done    (seg_done)
  );

  assign load_mod = active && burst && phase;
  assign busy     = active;

endmodule

// File: rtl/uplink_resp_encoder_chk.sv
module uplink_resp_encoder_chk #(
  parameter int DIV_LO = 16,
  parameter int DIV_HI = 14
) (
  input logic clk,
  input logic rst_n,
  input logic tx_valid,
  input logic tx_ready,
  input logic load_mod,
  input logic busy
);

  localparam int DIV_MAX = (DIV_LO > DIV_HI) ? DIV_LO : DIV_HI;
  localparam int RUN_W   = $clog2(DIV_MAX + 2) + 1;

  logic [RUN_W-1:0] hi_run_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      hi_run_q <= '0;
    end else if (load_mod) begin
      if (hi_run_q != {RUN_W{1'b1}}) begin
        hi_run_q <= hi_run_q + 1'b1;
      end
    end else begin
      hi_run_q <= '0;
    end
  end

  // R8: no modulation outside a frame
  assert_idle_quiet_R8: assert property (@(posedge clk) disable iff (!rst_n)
    !busy |-> !load_mod);

  // R8: the frame closes with the switch open
  assert_close_open_R8: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(busy) |-> !$past(load_mod));

  // R9: a pop needs a valid head and a running frame
  assert_pop_valid_R9: assert property (@(posedge clk) disable iff (!rst_n)
    tx_ready |-> (tx_valid && busy));

  // R2: a frame begins only from a valid queue head, without a pop
  assert_start_valid_R2: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(busy) |-> ($past(tx_valid) && !tx_ready));

  // R3: every closed-switch run is one subcarrier half-period
  assert_burst_width_R3: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(load_mod) |-> ((hi_run_q == RUN_W'(DIV_LO)) || (hi_run_q == RUN_W'(DIV_HI))));

  // R3: no run outlasts the longer half-period
  assert_burst_bound_R3: assert property (@(posedge clk) disable iff (!rst_n)
    load_mod |-> (hi_run_q < RUN_W'(DIV_MAX)));

endmodule

bind uplink_resp_encoder uplink_resp_encoder_chk #(
  .DIV_LO (DIV_LO),
  .DIV_HI (DIV_HI)
) u_chk (
  .clk      (clk),
  .rst_n    (rst_n),
  .tx_valid (tx_valid),
  .tx_ready (tx_ready),
  .load_mod (load_mod),
  .busy     (busy)
);

// File: tb/uplink_resp_encoder_tb.sv
`timescale 1ns/1ps
module uplink_resp_encoder_tb;

  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       cfg_dual = 1'b0;
  logic       cfg_low_rate = 1'b0;
  logic       tx_valid;
  logic [7:0] tx_data;
  logic       tx_last;
  logic       tx_ready;
  logic       load_mod;
  logic       busy;

  int errors = 0;
  int checks = 0;
  bit finished = 1'b0;

  // Bench-side transmit queue
  logic [7:0] fmem [0:7];
  logic       flast[0:7];
  int         n_avail = 0;
  int         rd_ptr = 0;
  logic       hold_off = 1'b0;
  logic       fifo_clr = 1'b0;

  assign tx_valid = (rd_ptr < n_avail) && !hold_off;
  assign tx_data  = fmem[rd_ptr[2:0]];
  assign tx_last  = flast[rd_ptr[2:0]];

  always @(posedge clk) begin
    if (fifo_clr) rd_ptr <= 0;
    else if (tx_ready && tx_valid) rd_ptr <= rd_ptr + 1;
  end

  always #4 clk = ~clk;

  uplink_resp_encoder u_dut (
    .clk          (clk),
    .rst_n        (rst_n),
    .cfg_dual     (cfg_dual),
    .cfg_low_rate (cfg_low_rate),
    .tx_valid     (tx_valid),
    .tx_data      (tx_data),
    .tx_last      (tx_last),
    .tx_ready     (tx_ready),
    .load_mod     (load_mod),
    .busy         (busy)
  );

  // Expected segment list: sym 0 = A (lower subcarrier), 1 = B (silence or higher)
  int seg_b  [0:191];
  int seg_u  [0:191];
  int seg_pop[0:191];
  int nseg;

  task automatic add_seg(input int b, input int u, input int pop);
    seg_b[nseg]   = b;
    seg_u[nseg]   = u;
    seg_pop[nseg] = pop;
    nseg++;
  endtask

  task automatic check(input string tag, input bit ok, input int act, input int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s: actual=%0d expected=%0d", tag, act, exp);
    end
  endtask

  task automatic build(input int navail, input bit starve);
    int i;
    bit more;
    nseg = 0;
    // R7: start pattern B x3, A x3, then a 1 bit (B, A)
    add_seg(1, 3, 0);
    add_seg(0, 3, 0);
    add_seg(1, 1, 0);
    add_seg(0, 1, (navail > 0 && !starve) ? 1 : 0);
    i = 0;
    more = (navail > 0) && !starve;
    while (more) begin
      for (int k = 0; k < 8; k++) begin
        int bv;
        int pop_here;
        bv = fmem[i][k];
        pop_here = (k == 7 && !flast[i] && (i + 1) < navail) ? 1 : 0;
        add_seg(bv, 1, 0);
        add_seg(1 - bv, 1, pop_here);
      end
      more = !flast[i] && (i + 1) < navail;
      i++;
    end
    // R8: end pattern A, B, A x3, B x3
    add_seg(0, 1, 0);
    add_seg(1, 1, 0);
    add_seg(0, 3, 0);
    add_seg(1, 3, 0);
  endtask

  task automatic run_frame(input string tag, input bit dual, input bit low,
                           input int navail, input int chg_at, input int hold_at);
    int cyc;
    int wave_bad, pop_bad, busy_bad;
    int bad_cyc, bad_act, bad_exp;
    int pop_cyc, pop_bad_cyc;
    build(navail, hold_at >= 0);
    @(negedge clk);
    fifo_clr = 1'b1;
    @(negedge clk);
    fifo_clr = 1'b0;
    cfg_dual = dual;
    cfg_low_rate = low;
    n_avail = navail;
    cyc = 0; wave_bad = 0; pop_bad = 0; busy_bad = 0;
    bad_cyc = -1; bad_act = 0; bad_exp = 0; pop_cyc = -1; pop_bad_cyc = -1;
    for (int s = 0; s < nseg; s++) begin
      int d, ht, len;
      bit brst;
      if (seg_b[s] == 0) begin d = 16; ht = 16; brst = 1'b1; end
      else if (dual)     begin d = 14; ht = 18; brst = 1'b1; end
      else               begin d = 16; ht = 16; brst = 1'b0; end
      len = d * ht * seg_u[s] * (low ? 4 : 1);
      for (int k = 0; k < len; k++) begin
        bit exp_mod, exp_pop;
        @(negedge clk);
        exp_mod = brst && (((k / d) % 2) == 0);
        exp_pop = (seg_pop[s] != 0) && (k == len - 1);
        if (load_mod !== exp_mod) begin
          if (wave_bad == 0) begin bad_cyc = cyc; bad_act = load_mod; bad_exp = exp_mod; end
          wave_bad++;
        end
        if (tx_ready !== exp_pop) begin
          if (pop_bad == 0) begin pop_bad_cyc = cyc; pop_cyc = tx_ready; end
          pop_bad++;
        end
        if (busy !== 1'b1) busy_bad++;
        if (cyc == chg_at) begin cfg_dual = !dual; cfg_low_rate = !low; end
        if (cyc == hold_at) hold_off = 1'b1;
        cyc++;
      end
    end
    check({tag, " waveform (first bad cycle in actual)"}, wave_bad == 0,
          (wave_bad == 0) ? 0 : bad_cyc * 2 + bad_act, (wave_bad == 0) ? 0 : bad_cyc * 2 + bad_exp);
    check({tag, " tx_ready timing R9 R10 (bad cycle*2+value)"}, pop_bad == 0,
          (pop_bad == 0) ? 0 : pop_bad_cyc * 2 + pop_cyc, (pop_bad == 0) ? 0 : pop_bad_cyc * 2 + (1 - pop_cyc));
    check({tag, " busy held R2"}, busy_bad == 0, busy_bad, 0);
    @(negedge clk);
    check({tag, " frame end R8 (busy*2+load_mod)"}, (busy === 1'b0) && (load_mod === 1'b0),
          busy * 2 + load_mod, 0);
    n_avail = 0;
    fifo_clr = 1'b1;
    @(negedge clk);
    fifo_clr = 1'b0;
    hold_off = 1'b0;
    cfg_dual = 1'b0;
    cfg_low_rate = 1'b0;
  endtask

  initial begin
    repeat (190000) @(posedge clk);
    if (!finished) begin
      errors++;
      checks++;
      $display("FAIL R2 watchdog: actual=running expected=finished");
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end

  initial begin
    for (int i = 0; i < 8; i++) begin fmem[i] = 8'h00; flast[i] = 1'b0; end
    repeat (3) @(negedge clk);
    // R1: reset state
    check("R1 load_mod in reset", load_mod === 1'b0, load_mod, 0);
    check("R1 busy in reset", busy === 1'b0, busy, 0);
    check("R1 tx_ready in reset", tx_ready === 1'b0, tx_ready, 0);
    rst_n = 1'b1;
    repeat (10) @(negedge clk);
    check("R1 idle after reset", (busy === 1'b0) && (load_mod === 1'b0), busy * 2 + load_mod, 0);

    // R5 R7 R8 R9: one subcarrier, high rate, single byte
    fmem[0] = 8'hA5; flast[0] = 1'b1;
    run_frame("R5 R7 single-high A5", 1'b0, 1'b0, 1, -1, -1);

    // R6 R3 R4 R9: two subcarriers, high rate, three bytes
    fmem[0] = 8'h00; flast[0] = 1'b0;
    fmem[1] = 8'hFF; flast[1] = 1'b0;
    fmem[2] = 8'h3C; flast[2] = 1'b1;
    run_frame("R6 R3 dual-high 00 FF 3C", 1'b1, 1'b0, 3, -1, -1);

    // R4: low rate, one subcarrier
    fmem[0] = 8'h96; flast[0] = 1'b1;
    run_frame("R4 R5 single-low 96", 1'b0, 1'b1, 1, -1, -1);

    // R4 R6: low rate, two subcarriers
    fmem[0] = 8'h01; flast[0] = 1'b1;
    run_frame("R4 R6 dual-low 01", 1'b1, 1'b1, 1, -1, -1);

    // R10: queue empties after a byte without tx_last
    fmem[0] = 8'h5A; flast[0] = 1'b0;
    run_frame("R10 dual-high underrun", 1'b1, 1'b0, 1, -1, -1);

    // R10: head withdrawn before the start pattern ends
    fmem[0] = 8'h77; flast[0] = 1'b1;
    run_frame("R10 R7 R8 single-high starved", 1'b0, 1'b0, 1, -1, 3);

    // R2: configuration flipped mid-frame has no effect
    fmem[0] = 8'hC3; flast[0] = 1'b1;
    run_frame("R2 single-high cfg change", 1'b0, 1'b0, 1, 900, -1);

    // R10 R9: tx_last on the second byte
    fmem[0] = 8'h81; flast[0] = 1'b0;
    fmem[1] = 8'h7E; flast[1] = 1'b1;
    run_frame("R10 R9 dual-high 81 7E", 1'b1, 1'b0, 2, 2500, -1);

    finished = 1'b1;
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

endmodule